// File: doc/BRIEF.md
# Dual-Pattern Convolutional Byte Deinterleaver

This block reverses a transmitter's convolutional byte interleaving. Received bytes are dealt out in turn to a set of branches; each branch is a fixed-length FIFO, and the branch lengths shrink linearly from the first branch down to a final branch with no delay. Once the FIFOs have filled, the bytes come out in their original order. The sync byte of each packet always goes through branch 0. A packet-sync flag on the input forces the branch selector back to branch 0, so the block locks to packet boundaries.

Two patterns are supported. Pattern A uses `BR_A` branches (12 by default), and branch j delays by `DA*(BR_A-1-j)` visits. Pattern B uses `BR_B` branches (13 by default), and branch j delays by `DB*(BR_B-1-j)` visits. All branch FIFOs of both patterns sit in one shared RAM. Each branch has its own circular pointer, and a base address is computed for each branch, so the two patterns differ only in address generation. The pattern is read from the `mode` pin during a synchronous reset.

Top module: `conv_deintlv`

## Requirements
- R1: While `rst` is high, the pattern is taken from `mode` (0 = pattern A, 1 = pattern B). After reset, `out_valid`, `out_sync` and `misalign` are 0, the branch selector is at 0 and no branch holds data.
- R2: In pattern A, input byte n is written to branch j. For a byte arriving at branch j, the byte output is the byte written to branch j `DA*(BR_A-1-j)` visits earlier. Branch `BR_A-1` passes its byte straight through.
- R3: In pattern B, the same rule applies with `BR_B` branches and delay `DB*(BR_B-1-j)` on branch j.
- R4: The output for an accepted input byte appears exactly one clock later. `out_valid` is 0 in the cycle after a cycle with `in_valid` low.
- R5: `out_valid` stays 0 until every delaying branch has received at least as many bytes as its delay. From then on it is 1 for every accepted byte.
- R6: An accepted byte with `in_sync` high is written to branch 0, and the next byte goes to branch 1. Without a sync, the selector advances by one per accepted byte and wraps from the last branch to 0.
- R7: A sync that arrives while the selector is not at 0 sets `misalign`. The flag stays set until the next reset.
- R8: A change on `mode` outside reset has no effect on the active pattern.
- R9: `out_sync` is 1 exactly on an output byte read from branch 0 that was written with `in_sync` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; also samples `mode` |
| mode | input | 1 | Pattern select: 0 = A, 1 = B |
| in_valid | input | 1 | Input byte strobe |
| in_sync | input | 1 | Marks the packet sync byte |
| in_data | input | DW | Input byte |
| out_valid | output | 1 | Output byte strobe |
| out_sync | output | 1 | Marks the delayed sync byte |
| out_data | output | DW | Deinterleaved byte |
| misalign | output | 1 | Sticky flag for a sync seen off branch 0 |

## Verification
The bench uses small delay multipliers and compares every output against a per-branch FIFO model built from the delay formulas. It first runs pattern A with periodic syncs and gaps in `in_valid`. The gaps separate correct valid timing from a design that advances on idle cycles. Partway through that run `mode` is toggled, and the output must stay on pattern A. A pattern B run then exercises the second addressing scheme. A final run begins with unsynchronised bytes followed by a late sync. This checks that the selector is forced back to branch 0, that the misalign flag sets and stays set, and that branches holding uneven counts still produce the right bytes.

// File: rtl/conv_deintlv.sv
module conv_deintlv #(
  parameter int DW   = 8,
  parameter int BR_A = 12,
  parameter int BR_B = 13,
  parameter int DA   = 17,
  parameter int DB   = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode,
  input  logic          in_valid,
  input  logic          in_sync,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic          out_sync,
  output logic [DW-1:0] out_data,
  output logic          misalign
);
  localparam int SZ_A = DA * BR_A * (BR_A - 1) / 2;
  localparam int SZ_B = DB * BR_B * (BR_B - 1) / 2;
  localparam int RD   = (SZ_A > SZ_B) ? SZ_A : SZ_B;
  localparam int AW   = (RD > 1) ? $clog2(RD) : 1;
  localparam int MD_A = DA * (BR_A - 1);
  localparam int MD_B = DB * (BR_B - 1);
  localparam int PW   = $clog2(((MD_A > MD_B) ? MD_A : MD_B) + 1);
  localparam int NBX  = (BR_A > BR_B) ? BR_A : BR_B;
  localparam int BW   = $clog2(NBX);

  logic          mode_q;
  logic [BW-1:0] br;
  logic [PW-1:0] ptr [NBX];
  logic [NBX-1:0] fill;
  logic [DW:0]   mem [RD];
  logic [DW:0]   rdq;
  logic [DW-1:0] pass_q;
  logic          pt_q, c0_q, vout_q, mis_q;

  logic [BW-1:0] cur;
  logic [31:0]   nb_w, dd_w, dep_w, base_w;
  logic [AW-1:0] addr;
  logic          wrap, allfill;

  assign cur    = (in_valid && in_sync) ? '0 : br;
  assign nb_w   = mode_q ? 32'(BR_B) : 32'(BR_A);
  assign dd_w   = mode_q ? 32'(DB) : 32'(DA);
  assign dep_w  = dd_w * (nb_w - 32'd1 - 32'(cur));
  assign base_w = dd_w * ((32'(cur) * (2 * nb_w - 32'd1 - 32'(cur))) >> 1);
  assign addr   = AW'(base_w + 32'(ptr[cur]));
  assign wrap   = (32'(ptr[cur]) == dep_w - 32'd1);

  always_comb begin
    allfill = 1'b1;
    for (int j = 0; j < NBX; j++)
      if (32'(j) < nb_w - 32'd1 && !fill[j]) allfill = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= mode;
      br     <= '0;
      fill   <= '0;
      vout_q <= 1'b0;
      mis_q  <= 1'b0;
      for (int j = 0; j < NBX; j++) ptr[j] <= '0;
    end else begin
      vout_q <= in_valid && allfill;
      if (in_valid) begin
        br <= (32'(cur) == nb_w - 32'd1) ? '0 : cur + 1'b1;
        if (in_sync && br != '0) mis_q <= 1'b1;
        if (dep_w != 32'd0) begin
          ptr[cur] <= wrap ? '0 : ptr[cur] + 1'b1;
          if (wrap) fill[cur] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && !rst) begin
      pt_q   <= (dep_w == 32'd0);
      pass_q <= in_data;
      c0_q   <= (cur == '0);
      if (dep_w != 32'd0) begin
        rdq       <= mem[addr];
        mem[addr] <= {in_sync, in_data};
      end
    end
  end

  assign out_valid = vout_q;
  assign out_data  = pt_q ? pass_q : rdq[DW-1:0];
  assign out_sync  = vout_q && !pt_q && c0_q && rdq[DW];
  assign misalign  = mis_q;

  // R4
  lat_one_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R7
  mis_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    misalign |=> misalign);
  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(mode_q));
  // R6
  sync_branch_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sync) |=> (br == BW'(1)));
  // R6
  br_range_chk: assert property (@(posedge clk) disable iff (rst)
    32'(br) < nb_w);
endmodule

// File: tb/sim_conv_deintlv.sv
module sim_conv_deintlv;
  localparam int DA = 2, DB = 1;
  logic clk = 0, rst = 1, mode = 0, in_valid = 0, in_sync = 0;
  logic [7:0] in_data = 0;
  logic out_valid, out_sync, misalign;
  logic [7:0] out_data;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  conv_deintlv #(.DW(8), .BR_A(12), .BR_B(13), .DA(DA), .DB(DB)) u0 (
    .clk(clk), .rst(rst), .mode(mode), .in_valid(in_valid), .in_sync(in_sync),
    .in_data(in_data), .out_valid(out_valid), .out_sync(out_sync),
    .out_data(out_data), .misalign(misalign));

  logic [8:0] hist [13][64];
  int cnt [13];
  int nb, dm, bidx;
  logic mb, ev, es, emis;
  logic [7:0] ed;
  string tg = "R2";

  function automatic int dep(int j);
    return dm * (nb - 1 - j);
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("R4", 32'(out_valid), 32'(ev), "out_valid");
    chk("R7", 32'(misalign), 32'(emis), "misalign");
    if (ev) begin
      chk(tg, 32'(out_data), 32'(ed), "out_data");
      chk("R9", 32'(out_sync), 32'(es), "out_sync");
    end else chk("R9", 32'(out_sync), 0, "out_sync idle");
  endtask

  task automatic do_reset(logic m);
    @(negedge clk);
    rst = 1; mode = m; in_valid = 0; in_sync = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    mb = m; nb = m ? 13 : 12; dm = m ? DB : DA; bidx = 0;
    ev = 0; es = 0; emis = 0;
    for (int j = 0; j < 13; j++) cnt[j] = 0;
    chk("R1", 32'({out_valid, out_sync, misalign}), 0, "reset state");
  endtask

  task automatic push(logic v, logic s, logic [7:0] d);
    int j;
    logic af;
    @(negedge clk);
    compare();
    in_valid = v; in_sync = s; in_data = d;
    ev = 0; es = 0;
    if (v) begin
      j = s ? 0 : bidx;
      af = 1;
      for (int k = 0; k < nb - 1; k++) if (cnt[k] < dep(k)) af = 0;
      ev = af;
      if (dep(j) == 0) begin ed = d; es = 0; end
      else if (cnt[j] >= dep(j)) {es, ed} = hist[j][(cnt[j] - dep(j)) % 64];
      hist[j][cnt[j] % 64] = {s, d};
      cnt[j]++;
      if (s && bidx != 0) emis = 1;
      bidx = (j == nb - 1) ? 0 : j + 1;
    end
  endtask

  function automatic logic [7:0] val(int t);
    return 8'((t * 29 + t / 7 + 5) & 255);
  endfunction

  initial begin
    #(20ns * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1, R2, R4, R5, R8, R9: pattern A with gaps and a mode toggle
    do_reset(0);
    tg = "R2";
    for (int t = 0; t < 800; t++) begin
      if (t == 450) begin mode = 1; tg = "R8"; end
      if (t % 7 == 6) push(0, 0, 8'h00);
      else push(1, (t % 48) == 0, val(t));
    end
    // R3: pattern B
    do_reset(1);
    tg = "R3";
    for (int t = 0; t < 450; t++) push(1, (t % 52) == 0, val(t + 3));
    // R6, R7: unsynchronised prefix, late sync
    do_reset(0);
    tg = "R6";
    for (int t = 0; t < 5; t++) push(1, 0, val(t + 100));
    for (int t = 0; t < 450; t++) push(1, (t % 48) == 0, val(t + 200));
    push(0, 0, 8'h00);
    push(0, 0, 8'h00);
    chk("R7", 32'(misalign), 1, "misalign held");
    // R1, R7: reset clears the flag
    do_reset(0);
    chk("R7", 32'(misalign), 0, "misalign cleared by reset");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule